// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the serial clock waveform for an I2C master from the chip's functional clock. A programmable prescaler divides the functional clock into an internal sampling tick. Two programmable counts then set how many ticks SCL stays low and how many it stays high. Each phase carries a fixed hardware addition: 7 ticks on the low phase and 5 ticks on the high phase. One SCL period therefore lasts (prescale+1)\*(low+7+high+5) functional clocks. With a 48 MHz functional clock and a prescale of 1, low/high counts of 111/117 give 100 kHz, 23/25 give 400 kHz and 5/7 give 1 MHz.

Each count register holds two 8-bit fields. The lower byte is used in standard/fast operation. The upper byte is used only when high-speed operation is selected. Around the SCL level, the block emits single-cycle strobes at each falling and rising edge and a sample strobe in the middle of the high phase. A byte engine uses these strobes to shift data and to sample SDA. START/STOP sequencing, data shifting, clock stretching and arbitration belong to neighbouring logic.

Configuration is captured in shadow registers only at the start of a period. Software can therefore rewrite the registers at any time without producing a truncated or stretched phase.

Top module: `scl_rate_gen`

## Requirements
- R1: The internal tick fires once every (prescale+1) functional clocks while the generator runs, so every phase length is a whole multiple of (prescale+1) cycles.
- R2: SCL stays low for exactly (L+7)\*(prescale+1) clock cycles per period, where L is the selected low count.
- R3: SCL stays high for exactly (H+5)\*(prescale+1) clock cycles per period, where H is the selected high count.
- R4: When `hs_mode` is 0, L and H are taken from bits [7:0] of `low_cfg` and `high_cfg`. When `hs_mode` is 1, they are taken from bits [15:8] of those ports.
- R5: Prescale, count and mode inputs are captured only at a falling edge of SCL (including the first one after activation). A change made during a period alters neither that period's low phase nor its high phase; it applies from the next period.
- R6: Unless both `enable` and `run` are 1, SCL is driven high and no strobe is produced. Stopping never emits a strobe, and SCL returns high in the cycle after the request drops.
- R7: `scl_fall` is high for exactly the first cycle in which `scl_out` is low. `scl_rise` is high for exactly the first cycle in which `scl_out` is high after a low phase.
- R8: `scl_sample` is high for one cycle per high phase. It is asserted floor((H+5)/2)\*(prescale+1) cycles after the cycle of `scl_rise`.
- R9: A period always begins with the low phase. When the generator is activated at a clock edge, `scl_fall` and a low `scl_out` appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| run | input | 1 | Request to generate SCL periods |
| hs_mode | input | 1 | Selects the high-speed count fields |
| psc_val | input | PSC_W (8) | Prescale value; tick = clock/(value+1) |
| low_cfg | input | 2\*CNT_W (16) | Low counts: [7:0] standard/fast, [15:8] high-speed |
| high_cfg | input | 2\*CNT_W (16) | High counts: [7:0] standard/fast, [15:8] high-speed |
| scl_out | output | 1 | SCL level |
| scl_rise | output | 1 | One-cycle strobe in the first high cycle |
| scl_fall | output | 1 | One-cycle strobe in the first low cycle |
| scl_sample | output | 1 | One-cycle strobe in the middle of the high phase |

## Verification
The bench uses the default parameters: an 8-bit prescaler and 8-bit count fields with offsets 7 and 5. At these widths the full-scale 255/255 counts and the all-zero minimum periods (7 and 5 ticks) can be reached within a short run. It also covers the three published 48 MHz settings, prescale values from 0 to 3, and a high-speed vector whose upper and lower bytes differ. A change made in the middle of a low phase demonstrates that reloads happen only at a period boundary.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_q,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             wrap;

  assign wrap = (pcnt_q == psc_q);
  assign tick = !clr && wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr || wrap) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R1: the divider never runs past the captured prescale value
  assert_pcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= psc_q);
  // R1: a cleared divider restarts from zero
  assert_clr_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pcnt_q == '0);
endmodule

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LEN_W    = CNT_W + 1,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               hs_mode,
  input  logic [PSC_W-1:0]   psc_in,
  input  logic [2*CNT_W-1:0] low_in,
  input  logic [2*CNT_W-1:0] high_in,
  output logic [PSC_W-1:0]   psc_q,
  output logic [LEN_W-1:0]   low_len,
  output logic [LEN_W-1:0]   high_len
);
  logic [CNT_W-1:0] low_sel, high_sel;
  logic [LEN_W-1:0] low_len_d, high_len_d;

  always_comb begin
    if (hs_mode) begin
      low_sel  = low_in[2*CNT_W-1:CNT_W];
      high_sel = high_in[2*CNT_W-1:CNT_W];
    end else begin
      low_sel  = low_in[CNT_W-1:0];
      high_sel = high_in[CNT_W-1:0];
    end
    low_len_d  = LEN_W'(low_sel)  + LEN_W'(LOW_OFS);
    high_len_d = LEN_W'(high_sel) + LEN_W'(HIGH_OFS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q    <= '0;
      low_len  <= LEN_W'(LOW_OFS);
      high_len <= LEN_W'(HIGH_OFS);
    end else if (load) begin
      psc_q    <= psc_in;
      low_len  <= low_len_d;
      high_len <= high_len_d;
    end
  end

  // R5: captured settings move only on a period-boundary load
  assert_hold_between_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(psc_q) && $stable(low_len) && $stable(high_len));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_rate_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             running,
  output logic             load,
  output logic             scl_out,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             scl_sample
);
  scl_phase_e       ph_q, ph_d;
  logic [LEN_W-1:0] tcnt_q, tcnt_d;
  logic             scl_d, rise_d, fall_d, samp_d;
  logic             last_low, last_high, mid_high;

  assign running   = (ph_q != PH_IDLE);
  assign last_low  = (tcnt_q == low_len - 1'b1);
  assign last_high = (tcnt_q == high_len - 1'b1);
  assign mid_high  = (tcnt_q == (high_len >> 1) - 1'b1);

  always_comb begin
    ph_d   = ph_q;
    tcnt_d = tcnt_q;
    scl_d  = scl_out;
    rise_d = 1'b0;
    fall_d = 1'b0;
    samp_d = 1'b0;
    load   = 1'b0;
    if (!active) begin
      ph_d   = PH_IDLE;
      tcnt_d = '0;
      scl_d  = 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          tcnt_d = '0;
          scl_d  = 1'b0;
          fall_d = 1'b1;
          load   = 1'b1;
        end
        PH_LOW: if (tick) begin
          if (last_low) begin
            ph_d   = PH_HIGH;
            tcnt_d = '0;
            scl_d  = 1'b1;
            rise_d = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        PH_HIGH: if (tick) begin
          samp_d = mid_high;
          if (last_high) begin
            ph_d   = PH_LOW;
            tcnt_d = '0;
            scl_d  = 1'b0;
            fall_d = 1'b1;
            load   = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          scl_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      tcnt_q     <= '0;
      scl_out    <= 1'b1;
      scl_rise   <= 1'b0;
      scl_fall   <= 1'b0;
      scl_sample <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      tcnt_q     <= tcnt_d;
      scl_out    <= scl_d;
      scl_rise   <= rise_d;
      scl_fall   <= fall_d;
      scl_sample <= samp_d;
    end
  end

  // R2: the tick count never exceeds the low phase length
  assert_low_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOW) |-> tcnt_q < low_len);
  // R3: the tick count never exceeds the high phase length
  assert_high_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH) |-> tcnt_q < high_len);
  // R6: an inactive request leaves SCL high and quiet
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> scl_out && !scl_rise && !scl_fall && !scl_sample);
  // R7: the rise strobe marks a real low-to-high change
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> scl_out && !$past(scl_out));
  // R7: the fall strobe marks a real high-to-low change
  assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_out && $past(scl_out));
  // R8: the sample strobe only occurs while SCL is high, never alongside an edge strobe
  assert_sample_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_sample |-> scl_out && $onehot0({scl_rise, scl_fall, scl_sample}));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               run,
  input  logic               hs_mode,
  input  logic [PSC_W-1:0]   psc_val,
  input  logic [2*CNT_W-1:0] low_cfg,
  input  logic [2*CNT_W-1:0] high_cfg,
  output logic               scl_out,
  output logic               scl_rise,
  output logic               scl_fall,
  output logic               scl_sample
);
  localparam int LEN_W = CNT_W + 1;

  logic             active, running, load, tick;
  logic [PSC_W-1:0] psc_q;
  logic [LEN_W-1:0] low_len, high_len;

  assign active = enable && run;

  scl_cfg_shadow #(
    .PSC_W(PSC_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .hs_mode(hs_mode),
    .psc_in(psc_val), .low_in(low_cfg), .high_in(high_cfg),
    .psc_q(psc_q), .low_len(low_len), .high_len(high_len)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(!active || !running),
    .psc_q(psc_q), .tick(tick)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
    .low_len(low_len), .high_len(high_len),
    .running(running), .load(load), .scl_out(scl_out),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_sample(scl_sample)
  );

  // R9: activation from idle yields a falling edge on the next cycle
  assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !running) |=> scl_fall && !scl_out);
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n, enable, run, hs_mode;
  logic [7:0]  psc_val;
  logic [15:0] low_cfg, high_cfg;
  logic        scl_out, scl_rise, scl_fall, scl_sample;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .hs_mode(hs_mode),
    .psc_val(psc_val), .low_cfg(low_cfg), .high_cfg(high_cfg),
    .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .scl_sample(scl_sample)
  );

  // {hs_mode, prescale, low_cfg, high_cfg}
  localparam logic [40:0] VEC [7] = '{
    {1'b0, 8'd1, 16'h006F, 16'h0075},
    {1'b0, 8'd1, 16'h0017, 16'h0019},
    {1'b0, 8'd1, 16'h0005, 16'h0007},
    {1'b0, 8'd0, 16'h0000, 16'h0000},
    {1'b1, 8'd0, 16'h0305, 16'h0A07},
    {1'b0, 8'd3, 16'h0305, 16'h0A07},
    {1'b0, 8'd0, 16'h00FF, 16'h00FF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge where scl_fall is seen; counts low, high and sample offset.
  task automatic measure(input bit chg, output int lo, output int hi, output int smp);
    while (!scl_fall) @(negedge clk);
    lo = 0;
    do begin
      if (chg && lo == 3) begin
        low_cfg  = 16'h0014;
        high_cfg = 16'h0010;
      end
      lo++;
      @(negedge clk);
    end while (!scl_rise);
    hi = 0;
    smp = -1;
    do begin
      if (scl_sample) smp = hi;
      hi++;
      @(negedge clk);
    end while (!scl_fall);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lo, hi, smp;
    rst_n = 1'b0; enable = 1'b0; run = 1'b0; hs_mode = 1'b0;
    psc_val = '0; low_cfg = '0; high_cfg = '0;
    repeat (3) @(negedge clk);
    // reset state, R6
    check(scl_out == 1'b1, "R6 reset scl", int'(scl_out), 1);
    check({scl_rise, scl_fall, scl_sample} == 3'b000, "R6 reset strobes",
          int'({scl_rise, scl_fall, scl_sample}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: run without enable must stay idle
    run = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!scl_out || scl_rise || scl_fall || scl_sample) bad++;
      end
      check(bad == 0, "R6 disabled idle", bad, 0);
    end
    run = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R8 R9
    for (int v = 0; v < 7; v++) begin
      int p, l, h, le, he;
      hs_mode  = VEC[v][40];
      psc_val  = VEC[v][39:32];
      low_cfg  = VEC[v][31:16];
      high_cfg = VEC[v][15:0];
      p  = int'(psc_val) + 1;
      l  = hs_mode ? int'(low_cfg[15:8])  : int'(low_cfg[7:0]);
      h  = hs_mode ? int'(high_cfg[15:8]) : int'(high_cfg[7:0]);
      le = (l + 7) * p;
      he = (h + 5) * p;
      run = 1'b1;
      @(negedge clk);
      check(scl_fall && !scl_out, "R9 first fall", int'(scl_fall), 1);
      measure(1'b0, lo, hi, smp);
      check(lo == le, "R2/R4/R1 low length", lo, le);
      check(hi == he, "R3/R4/R1 high length", hi, he);
      check(smp == ((h + 5) / 2) * p, "R8 sample position", smp, ((h + 5) / 2) * p);
      // R6: stopping in the first low cycle gives SCL high, no rise strobe
      run = 1'b0;
      @(negedge clk);
      check(scl_out && !scl_rise && !scl_fall, "R6 stop", int'(scl_out), 1);
      repeat (2) @(negedge clk);
    end

    // R5: change mid low phase, applies only at next period
    hs_mode = 1'b0; psc_val = 8'd0; low_cfg = 16'h0005; high_cfg = 16'h0007;
    run = 1'b1;
    @(negedge clk);
    measure(1'b1, lo, hi, smp);
    check(lo == 12, "R5 current low unchanged", lo, 12);
    check(hi == 12, "R5 current high unchanged", hi, 12);
    measure(1'b0, lo, hi, smp);
    check(lo == 27, "R5 next low updated", lo, 27);
    check(hi == 21, "R5 next high updated", hi, 21);
    check(smp == 10, "R8 sample after update", smp, 10);
    run = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule